// File: doc/BRIEF.md
# Block-Framed Inverse Transform Stream Controller

This block sits in front of an 8x8 inverse-transform datapath. It decides which input cycles belong to a coefficient block. It keeps a running count of the samples taken into the current block. It drives a ready flag that tells the upstream source when a new block may begin.

A block opens on a start strobe that arrives together with a valid coefficient. The block then takes exactly 64 qualified samples, whatever their content. After that it returns to idle and waits for the next strobe. Holding the strobe high keeps consecutive blocks flowing with no idle cycle between them.

Every accepted cycle is pushed into a fixed-length delay line, and so is every idle cycle. The output therefore repeats the input pattern, gaps included, a fixed number of cycles later. The delay line also carries a start-of-block marker and a placeholder pixel. The pixel is the coefficient clipped to the unsigned pixel range; it stands in for the arithmetic, which lives elsewhere.

Top module: `idct_frame_ctrl`

## Requirements
- R1: A block opens in a cycle where `start_i` and `coef_vld_i` are both high while `ready_o` is high. `ready_o` is low from the next cycle on. It returns high in the cycle after the 64th accepted sample.
- R2: If `start_i` and `coef_vld_i` stay high continuously, blocks follow one another. `ready_o` is high for exactly one cycle between two blocks.
- R3: A high `start_i` while a block is in progress changes nothing. The block still ends after 64 accepted samples.
- R4: While idle, samples presented without `start_i` are not accepted. They produce no valid output and no start-of-block.
- R5: Inside a block, a cycle with `coef_vld_i` low does not advance the sample count. It appears as a cycle with `pix_vld_o` low at the output.
- R6: `pix_sob_o` is a one-cycle pulse 83 cycles after the cycle that opened a block (LATENCY = 83). It is never high without `pix_vld_o`.
- R7: `pix_vld_o` in cycle n+83 equals "a sample was accepted in cycle n". Input gaps are reproduced cycle for cycle.
- R8: When `pix_vld_o` is high, `pix_o` is the accepted coefficient, read as signed 11-bit, clipped to 0..255. When `pix_vld_o` is low, `pix_o` is 0.
- R9: A cycle with `clr_i` high accepts nothing. In the following cycle the block is idle (`ready_o` high). Every sample still in flight is discarded, so `pix_vld_o` and `pix_sob_o` stay low for the next 83 cycles unless new samples arrive.
- R10: While `rst_n` is low, `ready_o` is high and `pix_vld_o`, `pix_sob_o` and `pix_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear, active high |
| start_i | input | 1 | Start-of-block strobe from the source |
| coef_vld_i | input | 1 | A coefficient is present this cycle |
| coef_i | input | 11 | Signed coefficient |
| ready_o | output | 1 | High while the controller can open a new block |
| pix_o | output | 8 | Placeholder pixel, delayed by LATENCY |
| pix_vld_o | output | 1 | Output sample valid |
| pix_sob_o | output | 1 | First output sample of a block |

## Verification
The bench holds the strobe high through block boundaries. A controller that needs a fresh edge, or that inserts extra idle cycles, would fall behind the expected ready pattern. Random strobe pulses inside blocks go after controllers that restart their count on a repeated strobe; such a design would stretch blocks and misplace the start-of-block pulse. Sparse valid patterns catch a counter that advances on empty cycles or a delay line that squeezes out the gaps. A clear in the middle of a block, followed by unstrobed samples, exposes residue left in flight and a counter that is not reset. Coefficients at the extremes of the signed range and at the clip edges catch a wrong clip or a sign mistake.

// File: rtl/idct_frame_pkg.sv
package idct_frame_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_e;

  // Clip a signed value into 0..hi.
  function automatic int clip_range(input int value, input int hi);
    if (value < 0)       return 0;
    else if (value > hi) return hi;
    else                 return value;
  endfunction

endpackage

// File: rtl/idct_blk_seq.sv
module idct_blk_seq
  import idct_frame_pkg::*;
#(
  parameter int BLK_LEN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic start_i,
  input  logic vld_i,
  output logic ready_o,
  output logic take_o,
  output logic open_o,
  output logic close_o
);

  localparam int CNT_W = (BLK_LEN > 2) ? $clog2(BLK_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BLK_LEN - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  logic is_idle;
  assign is_idle = (state_q == SEQ_IDLE);

  always_comb begin
    open_o  = !clr_i && is_idle && start_i && vld_i;
    take_o  = open_o || (!clr_i && !is_idle && vld_i);
    close_o = !clr_i && !is_idle && vld_i && (cnt_q == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else if (clr_i) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else if (open_o) begin
      state_q <= SEQ_BUSY;
      cnt_q   <= CNT_W'(1);
    end else if (close_o) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else if (take_o) begin
      cnt_q   <= cnt_q + CNT_W'(1);
    end
  end

  assign ready_o = is_idle;

endmodule

// File: rtl/idct_lat_line.sv
module idct_lat_line #(
  parameter int DEPTH = 83,
  parameter int W     = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] tap [DEPTH+1];

  assign tap[0] = din;

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     tap[s+1] <= '0;
      else if (clr_i) tap[s+1] <= '0;
      else            tap[s+1] <= tap[s];
    end
  end

  assign dout = tap[DEPTH];

endmodule

// File: rtl/idct_frame_ctrl.sv
module idct_frame_ctrl
  import idct_frame_pkg::*;
#(
  parameter int COEF_W  = 11,
  parameter int PIX_W   = 8,
  parameter int BLK_LEN = 64,
  parameter int LATENCY = 83
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              start_i,
  input  logic              coef_vld_i,
  input  logic [COEF_W-1:0] coef_i,
  output logic              ready_o,
  output logic [PIX_W-1:0]  pix_o,
  output logic              pix_vld_o,
  output logic              pix_sob_o
);

  localparam int LINE_W  = PIX_W + 2;
  localparam int PIX_MAX = (1 << PIX_W) - 1;

  // named internal events
  logic take_w, open_w, close_w;
  logic [PIX_W-1:0]  pix_in_w;
  logic [LINE_W-1:0] line_in_w, line_out_w;

  idct_blk_seq #(.BLK_LEN(BLK_LEN)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr_i),
    .start_i (start_i),
    .vld_i   (coef_vld_i),
    .ready_o (ready_o),
    .take_o  (take_w),
    .open_o  (open_w),
    .close_o (close_w)
  );

  always_comb begin
    if (take_w) pix_in_w = PIX_W'(clip_range(int'($signed(coef_i)), PIX_MAX));
    else        pix_in_w = '0;
  end

  assign line_in_w = {open_w, take_w, pix_in_w};

  idct_lat_line #(.DEPTH(LATENCY), .W(LINE_W)) u_line (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (clr_i),
    .din   (line_in_w),
    .dout  (line_out_w)
  );

  assign pix_sob_o = line_out_w[PIX_W+1];
  assign pix_vld_o = line_out_w[PIX_W];
  assign pix_o     = line_out_w[PIX_W-1:0];

endmodule

// File: rtl/idct_frame_chk.sv
module idct_frame_chk #(
  parameter int BLK_LEN = 64,
  parameter int LATENCY = 83
) (
  input logic clk,
  input logic rst_n,
  input logic clr_i,
  input logic start_i,
  input logic ready_o,
  input logic take_w,
  input logic open_w,
  input logic pix_vld_o,
  input logic pix_sob_o
);

  int blk_cnt;
  int fly_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_cnt <= 0;
      fly_cnt <= 0;
    end else if (clr_i) begin
      blk_cnt <= 0;
      fly_cnt <= 0;
    end else begin
      if (take_w) blk_cnt <= (blk_cnt == BLK_LEN - 1) ? 0 : blk_cnt + 1;
      fly_cnt <= fly_cnt + (take_w ? 1 : 0) - (pix_vld_o ? 1 : 0);
    end
  end

  // R1
  open_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_w |=> !ready_o);

  // R1
  full_block_ready_chk: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
    (take_w && blk_cnt == BLK_LEN - 1) |=> ready_o);

  // R3
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_o && !clr_i && !(take_w && blk_cnt == BLK_LEN - 1)) |=> !ready_o);

  // R4
  idle_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !start_i) |-> !take_w);

  // R6
  sob_with_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_sob_o |-> pix_vld_o);

  // R7
  in_flight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fly_cnt >= 0) && (fly_cnt <= LATENCY));

  // R9
  clr_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (ready_o && !pix_vld_o && !pix_sob_o));

endmodule

bind idct_frame_ctrl idct_frame_chk #(.BLK_LEN(BLK_LEN), .LATENCY(LATENCY)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr_i     (clr_i),
  .start_i   (start_i),
  .ready_o   (ready_o),
  .take_w    (take_w),
  .open_w    (open_w),
  .pix_vld_o (pix_vld_o),
  .pix_sob_o (pix_sob_o)
);

// File: tb/idct_frame_ctrl_tb.sv
`timescale 1ns/1ps
module idct_frame_ctrl_tb;

  localparam int LAT  = 83;
  localparam int BLK  = 64;
  localparam int NRUN = 2100;
  localparam int NEXP = NRUN + LAT + 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_i = 1'b0;
  logic start_i = 1'b0;
  logic coef_vld_i = 1'b0;
  logic [10:0] coef_i = '0;
  logic ready_o, pix_vld_o, pix_sob_o;
  logic [7:0] pix_o;

  always #5 clk = ~clk;

  idct_frame_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .start_i(start_i),
    .coef_vld_i(coef_vld_i), .coef_i(coef_i), .ready_o(ready_o),
    .pix_o(pix_o), .pix_vld_o(pix_vld_o), .pix_sob_o(pix_sob_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  int exp_vld [NEXP];
  int exp_sob [NEXP];
  int exp_pix [NEXP];

  bit m_idle = 1;
  int m_cnt = 0;

  function automatic int pix_of(input int v);
    return (v > 255) ? 255 : ((v < 0) ? 0 : v);
  endfunction

  function automatic string phase_tag(input int c);
    if (c < 200)  return "R2";
    if (c < 600)  return "R3";
    if (c < 1000) return "R5";
    if (c < 1150) return "R4";
    if (c < 1260) return "R9";
    return "R1";
  endfunction

  task automatic check(input string req, input int c, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d (%s): got %0d expected %0d", req, c, phase_tag(c), got, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < NEXP; i++) begin
      exp_vld[i] = 0; exp_sob[i] = 0; exp_pix[i] = 0;
    end
  end

  initial begin : main
    int seed;
    int v;
    bit s, q, k, acc, opn;
    seed = 1234;
    v = $urandom(seed);
    repeat (3) @(negedge clk);
    // R10: reset state while rst_n is held low
    check("R10 ready", -1, int'(ready_o), 1);
    check("R10 vld", -1, int'(pix_vld_o), 0);
    check("R10 sob", -1, int'(pix_sob_o), 0);
    check("R10 pix", -1, int'(pix_o), 0);
    rst_n = 1'b1;
    for (int c = 0; c < NRUN; c++) begin
      // compare outputs of cycle c
      check("R1 ready", c, int'(ready_o), int'(m_idle));
      check("R6 sob", c, int'(pix_sob_o), exp_sob[c]);
      check("R7 vld", c, int'(pix_vld_o), exp_vld[c]);
      check("R8 pix", c, int'(pix_o), exp_pix[c]);
      // choose stimulus
      k = 0;
      if (c < 200)       begin s = 1; q = 1; end
      else if (c < 600)  begin s = 1'($urandom % 2); q = 1; end
      else if (c < 1000) begin s = 1'($urandom % 2); q = (($urandom % 10) < 7); end
      else if (c < 1150) begin s = 0; q = 1; end
      else if (c < 1180) begin s = 1; q = 1; end
      else if (c == 1180) begin s = 1; q = 1; k = 1; end
      else if (c < 1260) begin s = 0; q = 1; end
      else if (c < 2000) begin s = (($urandom % 8) == 0); q = (($urandom % 10) < 8); end
      else               begin s = 0; q = 0; end
      case ($urandom % 6)
        0: v = -1024;
        1: v = 1023;
        2: v = 255 + int'($urandom % 2);
        3: v = -1 + int'($urandom % 2);
        default: v = int'($urandom % 2048) - 1024;
      endcase
      start_i = s; coef_vld_i = q; clr_i = k; coef_i = 11'(v);
      // reference model of the controller
      acc = 0; opn = 0;
      if (k) begin
        m_idle = 1; m_cnt = 0;
        for (int j = c + 1; j <= c + LAT; j++) begin
          exp_vld[j] = 0; exp_sob[j] = 0; exp_pix[j] = 0;
        end
      end else if (m_idle) begin
        if (s && q) begin acc = 1; opn = 1; m_idle = 0; m_cnt = 1; end
      end else if (q) begin
        acc = 1; m_cnt++;
        if (m_cnt == BLK) begin m_idle = 1; m_cnt = 0; end
      end
      exp_vld[c + LAT] = int'(acc);
      exp_sob[c + LAT] = int'(opn);
      exp_pix[c + LAT] = acc ? pix_of(v) : 0;
      @(negedge clk);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : watchdog
    #3_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not end, got 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule